// File: doc/BRIEF.md
# Remote-Request Auto-Response Transmit Buffer

This block manages one transmit message buffer that answers remote-request frames without CPU involvement. The buffer stores a 4-bit state code, a frame identifier with its extended-format flag, a data length and a data payload. The CPU loads all of these in a single write. While the code is the waiting value `1010`, every received frame is examined. A remote request (RTR=1) whose format flag and identifier match the buffer moves the code to the pending value `1110`. That raises the transmit request, and the buffer enters arbitration.

While the code is pending, the buffer keeps requesting until the transmit engine reports success. Failed attempts, whether lost arbitration or a bus error, leave it pending so that it retries in a later round. After a success the code drops back to `1010` and a one-cycle done pulse is produced. The CPU can force a single transmission by writing `1110` itself. Any other code value the CPU writes switches the automatic behaviour off and is held until the next write.

Top module: `rrb_ctrl`

## Requirements
- R1: After reset the code output is `0000`, and tx_req and tx_done are 0.
- R2: A CPU write (cpu_wr=1) loads code, ID, format flag, DLC and data. All of them are visible on the outputs on the cycle after the write edge.
- R3: With code `1010`, a received frame with rx_valid=1, rx_rtr=1, a matching format flag and a matching ID sets the code to `1110` on the next edge, and tx_req rises with it.
- R4: A remote request whose ID or format flag differs from the buffer leaves the code unchanged.
- R5: A data frame (rx_rtr=0) that carries the buffer's own ID and format leaves the code unchanged.
- R6: With code `1110`, tx_ok returns the code to `1010` on the next edge, and tx_done is 1 for exactly that one cycle.
- R7: With code `1110`, tx_fail or an idle cycle keeps the code at `1110` and tx_req at 1. A later tx_ok still completes the response.
- R8: A CPU write of `1110` causes exactly one transmission, after which the code returns to `1010`.
- R9: Any code other than `1010` or `1110` written by the CPU is held. Remote requests and tx_ok do not change it, and tx_done stays 0.
- R10: When a CPU write and a hardware event fall in the same cycle, the written code wins and no tx_done is produced.
- R11: For a standard-format buffer (format flag 0), only the low STD_W ID bits are compared. A request that differs only above them still matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe for the whole buffer |
| cpu_code | input | 4 | Code value to write |
| cpu_id | input | ID_W | Identifier to write |
| cpu_ide | input | 1 | Format flag to write (1 = extended) |
| cpu_dlc | input | DLC_W | Data length to write |
| cpu_data | input | DATA_W | Payload to write |
| rx_valid | input | 1 | A received frame is presented this cycle |
| rx_rtr | input | 1 | Received frame is a remote request |
| rx_ide | input | 1 | Received frame format flag |
| rx_id | input | ID_W | Received frame identifier |
| tx_ok | input | 1 | Transmit engine reports success for this buffer |
| tx_fail | input | 1 | Transmit engine reports lost arbitration or error |
| code | output | 4 | Current buffer code |
| tx_req | output | 1 | Buffer requests arbitration |
| tx_done | output | 1 | One-cycle pulse after a successful transmission |
| tx_id | output | ID_W | Stored identifier |
| tx_ide | output | 1 | Stored format flag |
| tx_dlc | output | DLC_W | Stored data length |
| tx_data | output | DATA_W | Stored payload |

## Verification
The bench builds the block with ID_W=29, STD_W=11, DLC_W=4 and DATA_W=64. With a 29-bit ID and an 11-bit standard field, a standard-format request can differ from the buffer only in bits above bit 10 and still match. The same setting lets a request that shares the buffer's ID but uses the extended format be rejected. Together with retries after tx_fail, CPU-forced sends and collisions between a write and a hardware event, this covers every transition of the code.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam logic [3:0] CODE_OFF  = 4'b0000;
  localparam logic [3:0] CODE_WAIT = 4'b1010;
  localparam logic [3:0] CODE_PEND = 4'b1110;
endpackage

// File: rtl/rrb_match.sv
module rrb_match #(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic            rx_valid,
  input  logic            rx_rtr,
  input  logic            rx_ide,
  input  logic [ID_W-1:0] rx_id,
  input  logic            buf_ide,
  input  logic [ID_W-1:0] buf_id,
  output logic            hit
);
  logic std_eq, ext_eq, id_eq;

  // R11: standard frames compare only the low field
  assign std_eq = (rx_id[STD_W-1:0] == buf_id[STD_W-1:0]);
  assign ext_eq = (rx_id == buf_id);
  assign id_eq  = buf_ide ? ext_eq : std_eq;

  always_comb begin
    hit = 1'b0;
    if (rx_valid && rx_rtr && (rx_ide == buf_ide)) begin
      hit = id_eq;
    end
  end
endmodule

// File: rtl/rrb_store.sv
module rrb_store #(
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              wr_ide,
  input  logic [DLC_W-1:0]  wr_dlc,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ID_W-1:0]   id_q,
  output logic              ide_q,
  output logic [DLC_W-1:0]  dlc_q,
  output logic [DATA_W-1:0] data_q
);
  logic [ID_W-1:0]   id_d;
  logic              ide_d;
  logic [DLC_W-1:0]  dlc_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    id_d   = id_q;
    ide_d  = ide_q;
    dlc_d  = dlc_q;
    data_d = data_q;
    if (wr_en) begin
      id_d   = wr_id;
      ide_d  = wr_ide;
      dlc_d  = wr_dlc;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      ide_q  <= 1'b0;
      dlc_q  <= '0;
      data_q <= '0;
    end else begin
      id_q   <= id_d;
      ide_q  <= ide_d;
      dlc_q  <= dlc_d;
      data_q <= data_d;
    end
  end

  a_r2_fields_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (id_q == $past(wr_id)) && (dlc_q == $past(wr_dlc)) && (ide_q == $past(wr_ide)));
endmodule

// File: rtl/rrb_code_fsm.sv
module rrb_code_fsm
  import rrb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic [3:0] cpu_code,
  input  logic       hit,
  input  logic       rx_valid,
  input  logic       rx_rtr,
  input  logic       tx_ok,
  input  logic       tx_fail,
  output logic [3:0] code_q,
  output logic       tx_req,
  output logic       tx_done
);
  logic [3:0] code_d;
  logic       done_d;

  always_comb begin
    code_d = code_q;
    done_d = 1'b0;
    if (cpu_wr) begin
      code_d = cpu_code;                 // R10: CPU write has priority
    end else begin
      unique case (code_q)
        CODE_WAIT: begin
          if (hit) code_d = CODE_PEND;   // R3
        end
        CODE_PEND: begin
          if (tx_ok) begin
            code_d = CODE_WAIT;          // R6
            done_d = 1'b1;
          end else if (tx_fail) begin
            code_d = CODE_PEND;          // R7: retry later
          end
        end
        default: code_d = code_q;        // R9: hold
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CODE_OFF;
      tx_done <= 1'b0;
    end else begin
      code_q  <= code_d;
      tx_done <= done_d;
    end
  end

  assign tx_req = (code_q == CODE_PEND);

  a_r2_code_written: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (code_q == $past(cpu_code)) && !tx_done);
  a_r3_hit_needs_remote: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rx_valid && rx_rtr));
  a_r3_match_to_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && code_q == CODE_WAIT && hit) |=> tx_req);
  a_r6_done_return: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && tx_req && tx_ok) |=> (code_q == CODE_WAIT) && tx_done);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  a_r7_retry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && tx_req && !tx_ok) |=> tx_req);
  a_r9_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && code_q != CODE_WAIT && code_q != CODE_PEND) |=> ($stable(code_q) && !tx_done));
endmodule

// File: rtl/rrb_ctrl.sv
module rrb_ctrl #(
  parameter int ID_W   = 29,
  parameter int STD_W  = 11,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [3:0]        cpu_code,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic              cpu_ide,
  input  logic [DLC_W-1:0]  cpu_dlc,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              rx_valid,
  input  logic              rx_rtr,
  input  logic              rx_ide,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              tx_ok,
  input  logic              tx_fail,
  output logic [3:0]        code,
  output logic              tx_req,
  output logic              tx_done,
  output logic [ID_W-1:0]   tx_id,
  output logic              tx_ide,
  output logic [DLC_W-1:0]  tx_dlc,
  output logic [DATA_W-1:0] tx_data
);
  logic hit;

  rrb_store #(.ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr),
    .wr_id(cpu_id), .wr_ide(cpu_ide), .wr_dlc(cpu_dlc), .wr_data(cpu_data),
    .id_q(tx_id), .ide_q(tx_ide), .dlc_q(tx_dlc), .data_q(tx_data)
  );

  rrb_match #(.ID_W(ID_W), .STD_W(STD_W)) u_match (
    .rx_valid(rx_valid), .rx_rtr(rx_rtr), .rx_ide(rx_ide), .rx_id(rx_id),
    .buf_ide(tx_ide), .buf_id(tx_id), .hit(hit)
  );

  rrb_code_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_code(cpu_code),
    .hit(hit), .rx_valid(rx_valid), .rx_rtr(rx_rtr),
    .tx_ok(tx_ok), .tx_fail(tx_fail),
    .code_q(code), .tx_req(tx_req), .tx_done(tx_done)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'b0000) |-> (!tx_req && !tx_done));
endmodule

// File: tb/rrb_ctrl_tb_top.sv
`timescale 1ns/1ps
module rrb_ctrl_tb_top;
  localparam int ID_W = 29, STD_W = 11, DLC_W = 4, DATA_W = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_wr, cpu_ide, rx_valid, rx_rtr, rx_ide, tx_ok, tx_fail;
  logic [3:0] cpu_code;
  logic [ID_W-1:0] cpu_id, rx_id;
  logic [DLC_W-1:0] cpu_dlc;
  logic [DATA_W-1:0] cpu_data;
  logic [3:0] code;
  logic tx_req, tx_done, tx_ide;
  logic [ID_W-1:0] tx_id;
  logic [DLC_W-1:0] tx_dlc;
  logic [DATA_W-1:0] tx_data;

  always #2.5 clk = ~clk;

  rrb_ctrl #(.ID_W(ID_W), .STD_W(STD_W), .DLC_W(DLC_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_code(cpu_code),
    .cpu_id(cpu_id), .cpu_ide(cpu_ide), .cpu_dlc(cpu_dlc), .cpu_data(cpu_data),
    .rx_valid(rx_valid), .rx_rtr(rx_rtr), .rx_ide(rx_ide), .rx_id(rx_id),
    .tx_ok(tx_ok), .tx_fail(tx_fail), .code(code), .tx_req(tx_req),
    .tx_done(tx_done), .tx_id(tx_id), .tx_ide(tx_ide), .tx_dlc(tx_dlc),
    .tx_data(tx_data)
  );

  typedef struct {
    logic [3:0] code;
    logic       req;
    logic       done;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // driver: drive one cycle of stimulus and push the expected outcome
  task automatic step(input logic wr, input logic [3:0] wcode,
                      input logic rv, input logic rtr, input logic ide,
                      input logic [ID_W-1:0] rid, input logic ok, input logic fl,
                      input logic [3:0] e_code, input logic e_req,
                      input logic e_done, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_wr = wr; cpu_code = wcode;
    rx_valid = rv; rx_rtr = rtr; rx_ide = ide; rx_id = rid;
    tx_ok = ok; tx_fail = fl;
    e.code = e_code; e.req = e_req; e.done = e_done; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: sample 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check((code === e.code) && (tx_req === e.req) && (tx_done === e.done), e.tag,
              $sformatf("code=%b req=%b done=%b", code, tx_req, tx_done),
              $sformatf("code=%b req=%b done=%b", e.code, e.req, e.done));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  localparam logic [ID_W-1:0] MY_ID = 29'h0000_0155;

  initial begin
    rst_n = 1'b0;
    cpu_wr = 0; cpu_code = 4'h0; cpu_id = '0; cpu_ide = 0; cpu_dlc = '0; cpu_data = '0;
    rx_valid = 0; rx_rtr = 0; rx_ide = 0; rx_id = '0; tx_ok = 0; tx_fail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(code === 4'b0000 && tx_req === 1'b0 && tx_done === 1'b0, "R1 reset",
          $sformatf("%b/%b/%b", code, tx_req, tx_done), "0000/0/0");

    // R2: load standard-format buffer in waiting code
    cpu_id = MY_ID; cpu_ide = 1'b0; cpu_dlc = 4'd8; cpu_data = 64'hDEAD_BEEF_0123_4567;
    step(1, 4'b1010, 0, 0, 0, '0, 0, 0, 4'b1010, 0, 0, "R2 write wait code");
    @(negedge clk);
    check(tx_id === MY_ID && tx_ide === 1'b0 && tx_dlc === 4'd8 &&
          tx_data === 64'hDEAD_BEEF_0123_4567, "R2 fields",
          $sformatf("%h/%b/%0d/%h", tx_id, tx_ide, tx_dlc, tx_data), "155/0/8/deadbeef01234567");

    step(0, 4'h0, 1, 0, 0, MY_ID, 0, 0, 4'b1010, 0, 0, "R5 data frame same id");
    step(0, 4'h0, 1, 1, 0, 29'h0000_0156, 0, 0, 4'b1010, 0, 0, "R4 other id");
    step(0, 4'h0, 1, 1, 1, MY_ID, 0, 0, 4'b1010, 0, 0, "R4 other format");
    // R3 and R11: differs only above bit 10
    step(0, 4'h0, 1, 1, 0, MY_ID | 29'h0010_0000, 0, 0, 4'b1110, 1, 0, "R3 R11 match");
    step(0, 4'h0, 0, 0, 0, '0, 0, 1, 4'b1110, 1, 0, "R7 fail keeps pending");
    step(0, 4'h0, 0, 0, 0, '0, 0, 0, 4'b1110, 1, 0, "R7 idle keeps pending");
    step(0, 4'h0, 0, 0, 0, '0, 1, 0, 4'b1010, 0, 1, "R6 R7 success returns");
    step(0, 4'h0, 0, 0, 0, '0, 0, 0, 4'b1010, 0, 0, "R6 pulse one cycle");

    // R8: forced single transmission
    step(1, 4'b1110, 0, 0, 0, '0, 0, 0, 4'b1110, 1, 0, "R8 cpu force");
    step(0, 4'h0, 0, 0, 0, '0, 1, 0, 4'b1010, 0, 1, "R8 sent once");
    step(0, 4'h0, 0, 0, 0, '0, 1, 0, 4'b1010, 0, 0, "R8 no second send");

    // R9: other code held
    step(1, 4'b0100, 0, 0, 0, '0, 0, 0, 4'b0100, 0, 0, "R9 write other");
    step(0, 4'h0, 1, 1, 0, MY_ID, 0, 0, 4'b0100, 0, 0, "R9 request ignored");
    step(0, 4'h0, 0, 0, 0, '0, 1, 0, 4'b0100, 0, 0, "R9 tx_ok ignored");

    // R10: write wins over events
    step(1, 4'b1010, 0, 0, 0, '0, 0, 0, 4'b1010, 0, 0, "R10 back to wait");
    step(1, 4'b1000, 1, 1, 0, MY_ID, 0, 0, 4'b1000, 0, 0, "R10 write beats match");
    step(1, 4'b1110, 0, 0, 0, '0, 0, 0, 4'b1110, 1, 0, "R10 set pending");
    step(1, 4'b0010, 0, 0, 0, '0, 1, 0, 4'b0010, 0, 0, "R10 write beats tx_ok");

    // R11 extended buffer needs full match
    cpu_id = 29'h1ABC_0155; cpu_ide = 1'b1;
    step(1, 4'b1010, 0, 0, 0, '0, 0, 0, 4'b1010, 0, 0, "R2 ext write");
    step(0, 4'h0, 1, 1, 1, 29'h0ABC_0155, 0, 0, 4'b1010, 0, 0, "R11 ext upper differs");
    step(0, 4'h0, 1, 1, 1, 29'h1ABC_0155, 0, 0, 4'b1110, 1, 0, "R3 ext match");

    step(0, 4'h0, 0, 0, 0, '0, 0, 0, 4'b1110, 1, 0, "R7 hold");
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule